// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage for the data-processing instructions of a small RISC core. Each cycle it takes a 4-bit opcode, two 32-bit operands (already shifted and read from the register file), the current carry flag and a request to update the flags. From these it forms a 32-bit result, a write enable for the destination register and the next negative, zero, carry and overflow flags.

The result datapath is purely combinational. A flag register holds the four flags from one operation to the next. It loads the next-flag value on every clock edge, and that value equals the held flags whenever no update applies. Logical operations pass the held carry and overflow bits through unchanged.

The four probe opcodes (two compares and two tests) always update the flags and never request a register write. The other opcodes write a result and touch the flags only when the update request is high. An idle cycle (issue low) neither writes nor changes the flags. All pins are plain control and data wires with no handshake, because the unit accepts one operation every cycle and never stalls.

Top module: `dp_alu`

## Requirements
- R1: With opcode 4'hD (move), result equals B. With opcode 4'hF (move-inverted), result equals the bitwise complement of B.
- R2: Opcodes 4'h0, 4'h1, 4'hC and 4'hE give A AND B, A XOR B, A OR B and A AND NOT B (bit clear) respectively.
- R3: Opcode 4'h4 gives A+B, opcode 4'h2 gives A−B and opcode 4'h3 gives B−A, all modulo 2^32.
- R4: Opcode 4'h5 gives A+B+carry_in, opcode 4'h6 gives A−B−(1−carry_in) and opcode 4'h7 gives B−A−(1−carry_in).
- R5: wr_en is high exactly when issue is high and the opcode is not a probe. The probe opcodes are 4'h8 (flags from A AND B), 4'h9 (A XOR B), 4'hA (A−B) and 4'hB (A+B).
- R6: With issue high, a probe opcode always updates the flags, and any other opcode updates them only when set_flags is high.
- R7: On an update, N is bit 31 of the computed value and Z is 1 exactly when the computed value is zero. Flag vectors are packed as {N,Z,C,V} in bits [3:0].
- R8: On an arithmetic update, C is the unsigned carry out of the sum. For subtraction this means "no borrow": C=1 when the minuend is at least the subtrahend plus any borrow-in.
- R9: On an arithmetic update, V is 1 exactly on signed two's-complement overflow. Logical and move updates keep the previously held C and V.
- R10: flags_q is 0 after reset, loads flags_nxt on each rising edge and is unchanged across a cycle with issue low.
- R11: When no update applies, flags_nxt equals flags_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Operation present this cycle |
| opcode | input | 4 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry flag used by the carry variants |
| set_flags | input | 1 | Flag update request for non-probe opcodes |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Destination register write enable |
| flags_nxt | output | 4 | Next flags {N,Z,C,V} |
| flags_q | output | 4 | Held flags {N,Z,C,V} |

## Verification
Two things can happen in the same cycle here: a flag update, and the pass-through of the held C and V. When a logical operation with set_flags high follows an arithmetic one, it writes new N and Z while it must keep the C and V that the previous operation produced. The bench provokes this with random back-to-back operation pairs and with directed sequences (an overflowing add followed by a flag-setting bit clear). A model of the held flags in the bench judges every cycle's flags_nxt and flags_q.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
  typedef enum logic [3:0] {
    OP_AND    = 4'h0, OP_XOR    = 4'h1, OP_SUB    = 4'h2, OP_RSUB   = 4'h3,
    OP_ADD    = 4'h4, OP_ADDC   = 4'h5, OP_SUBC   = 4'h6, OP_RSUBC  = 4'h7,
    OP_TSTAND = 4'h8, OP_TSTXOR = 4'h9, OP_CMPSUB = 4'hA, OP_CMPADD = 4'hB,
    OP_OR     = 4'hC, OP_MOVE   = 4'hD, OP_CLR    = 4'hE, OP_MOVN   = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  function automatic logic op_is_probe(alu_op_e op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    case (op)
      OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC,
      OP_CMPSUB, OP_CMPADD: return 1'b1;
      default:              return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dpalu_addsub.sv
module dpalu_addsub
  import dpalu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cout,
  output logic           ovf
);
  localparam int WE = W + 1;

  logic [W-1:0]  x, y;
  logic          c0;
  logic [WE-1:0] full;

  always_comb begin
    x  = a;
    y  = b;
    c0 = 1'b0;
    case (op)
      OP_SUB, OP_CMPSUB: begin y = ~b; c0 = 1'b1; end
      OP_RSUB:           begin x = b; y = ~a; c0 = 1'b1; end
      OP_ADDC:           begin c0 = cin; end
      OP_SUBC:           begin y = ~b; c0 = cin; end
      OP_RSUBC:          begin x = b; y = ~a; c0 = cin; end
      default:           begin x = a; y = b; c0 = 1'b0; end
    endcase
  end

  assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c0};
  assign sum  = full[W-1:0];
  assign cout = full[WE-1];
  assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
  import dpalu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  res
);
  always_comb begin
    case (op)
      OP_AND, OP_TSTAND: res = a & b;
      OP_XOR, OP_TSTXOR: res = a ^ b;
      OP_OR:             res = a | b;
      OP_MOVE:           res = b;
      OP_CLR:            res = a & ~b;
      OP_MOVN:           res = ~b;
      default:           res = '0;
    endcase
  end
endmodule

// File: rtl/dpalu_flags.sv
module dpalu_flags
  import dpalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  alu_op_e       op,
  input  logic          set_flags,
  input  logic [W-1:0]  value,
  input  logic          cout,
  input  logic          ovf,
  output alu_flags_t    nxt,
  output alu_flags_t    q
);
  logic probe, arith, upd;

  assign probe = op_is_probe(op);
  assign arith = op_is_arith(op);
  assign upd   = issue && (probe || set_flags);

  always_comb begin
    nxt = q;
    if (upd) begin
      nxt.n = value[W-1];
      nxt.z = (value == '0);
      nxt.c = arith ? cout : q.c;
      nxt.v = arith ? ovf  : q.v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(q)); // R10
  AST_PROBE_SETS_Z: assert property (@(posedge clk) disable iff (!rst_n)
    issue && probe |=> q.z == ($past(value) == '0)); // R6
  AST_NOREQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !probe && !set_flags |=> q == $past(q)); // R11
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !arith |=> (q.c == $past(q.c)) && (q.v == $past(q.v))); // R9
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dpalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [3:0]    opcode,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic          carry_in,
  input  logic          set_flags,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic [3:0]    flags_nxt,
  output logic [3:0]    flags_q
);
  alu_op_e      op;
  logic [W-1:0] sum, lres, value;
  logic         cout, ovf;
  alu_flags_t   nxt_s, q_s;

  assign op = alu_op_e'(opcode);

  dpalu_addsub #(.W(W)) u_addsub (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(carry_in),
    .sum(sum), .cout(cout), .ovf(ovf)
  );

  dpalu_logic #(.W(W)) u_logic (
    .op(op), .a(opnd_a), .b(opnd_b), .res(lres)
  );

  assign value = op_is_arith(op) ? sum : lres;

  dpalu_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op),
    .set_flags(set_flags), .value(value), .cout(cout), .ovf(ovf),
    .nxt(nxt_s), .q(q_s)
  );

  assign result    = value;
  assign wr_en     = issue && !op_is_probe(op);
  assign flags_nxt = nxt_s;
  assign flags_q   = q_s;

  AST_PROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (opcode[3:2] == 2'b10) |=> !$past(wr_en)); // R5
endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        carry_in = 1'b0, set_flags = 1'b0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_nxt, flags_q;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic [3:0] mflags = 4'h0;

  always #2 clk = ~clk;

  dp_alu u_dp_alu (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .set_flags(set_flags), .result(result), .wr_en(wr_en),
    .flags_nxt(flags_nxt), .flags_q(flags_q)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string res_tag(logic [3:0] op);
    case (op)
      4'hD, 4'hF:             return "R1";
      4'h0, 4'h1, 4'hC, 4'hE: return "R2";
      4'h2, 4'h3, 4'h4:       return "R3";
      default:                return "R4";
    endcase
  endfunction

  task automatic model(input logic v, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic ci, input logic sf,
                       output logic [31:0] r, output logic w, output logic [3:0] nf,
                       output logic up, output logic ar);
    logic probe;
    logic c, ov;
    longint sa, sb, sr;
    logic [32:0] wide;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    probe = (op == 4'h8) || (op == 4'h9) || (op == 4'hA) || (op == 4'hB);
    ar = 1'b1; c = 1'b0; sr = 0; r = '0;
    case (op)
      4'h2, 4'hA: begin r = a - b; c = (a >= b); sr = sa - sb; end
      4'h3:       begin r = b - a; c = (b >= a); sr = sb - sa; end
      4'h4, 4'hB: begin wide = {1'b0, a} + {1'b0, b}; r = wide[31:0]; c = wide[32]; sr = sa + sb; end
      4'h5:       begin wide = {1'b0, a} + {1'b0, b} + 33'(ci); r = wide[31:0]; c = wide[32];
                        sr = sa + sb + longint'(ci); end
      4'h6:       begin r = a - b - 32'(!ci); c = ({1'b0, a} >= {1'b0, b} + 33'(!ci));
                        sr = sa - sb - longint'(!ci); end
      4'h7:       begin r = b - a - 32'(!ci); c = ({1'b0, b} >= {1'b0, a} + 33'(!ci));
                        sr = sb - sa - longint'(!ci); end
      default: begin
        ar = 1'b0;
        case (op)
          4'h0, 4'h8: r = a & b;
          4'h1, 4'h9: r = a ^ b;
          4'hC:       r = a | b;
          4'hD:       r = b;
          4'hE:       r = a & ~b;
          default:    r = ~b;
        endcase
      end
    endcase
    ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    w  = v && !probe;
    up = v && (probe || sf);
    nf = mflags;
    if (up) nf = {r[31], r == 32'h0, ar ? c : mflags[1], ar ? ov : mflags[0]};
  endtask

  task automatic apply(logic v, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic ci, logic sf);
    logic [31:0] r;
    logic w, up, ar;
    logic [3:0] nf;
    @(negedge clk);
    issue = v; opcode = op; opnd_a = a; opnd_b = b; carry_in = ci; set_flags = sf;
    #1;
    model(v, op, a, b, ci, sf, r, w, nf, up, ar);
    if (w) check(res_tag(op), "result", result, r);
    check("R5", "wr_en", 32'(wr_en), 32'(w));
    if (!up)     check("R11", "flags_nxt hold", 32'(flags_nxt), 32'(nf));
    else if (ar) check("R6 R7 R8 R9", "flags_nxt arith", 32'(flags_nxt), 32'(nf));
    else         check("R6 R7 R9", "flags_nxt logic", 32'(flags_nxt), 32'(nf));
    @(posedge clk);
    mflags = nf;
    #1;
    check("R10", "flags_q", 32'(flags_q), 32'(mflags));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1B));
    repeat (3) @(posedge clk);
    #1;
    check("R10", "flags_q after reset", 32'(flags_q), 32'h0);
    check("R5", "wr_en idle in reset", 32'(wr_en), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    apply(1, 4'hE, 32'hFFFF_FFFF, 32'h0000_001F, 0, 1);   // bit clear low five bits
    apply(1, 4'hD, 32'h0, 32'h1234_5678, 0, 0);
    apply(1, 4'hF, 32'h0, 32'h0000_00FF, 0, 1);
    apply(1, 4'h4, 32'h7FFF_FFFF, 32'h1, 0, 1);           // signed overflow
    apply(1, 4'hE, 32'h8000_0000, 32'h0, 0, 1);           // logic keeps C and V
    apply(1, 4'h2, 32'h0, 32'h1, 0, 1);                   // borrow: C=0
    apply(1, 4'h3, 32'h5, 32'h9, 0, 1);                   // reverse subtract
    apply(1, 4'h6, 32'h10, 32'h4, 0, 1);                  // subtract with borrow-in
    apply(1, 4'h7, 32'h4, 32'h10, 1, 1);
    apply(1, 4'h5, 32'hFFFF_FFFF, 32'h0, 1, 1);           // carry ripple to zero
    apply(1, 4'hA, 32'h33, 32'h33, 0, 0);                 // compare equal
    apply(1, 4'h8, 32'hF7, 32'h08, 0, 0);                 // test bit 3 clear
    apply(1, 4'h9, 32'hAA, 32'hAA, 0, 0);
    apply(1, 4'hB, 32'h8000_0000, 32'h8000_0000, 0, 0);
    apply(0, 4'hA, 32'h1, 32'h2, 0, 1);                   // idle probe: no effect
    apply(1, 4'h4, 32'h1, 32'h2, 0, 0);                   // no request: hold

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (($urandom() % 8) == 0) rb = ra;
      if (($urandom() % 16) == 0) ra = 32'h8000_0000;
      apply(($urandom() % 10) != 0, 4'($urandom()), ra, rb, 1'($urandom()), 1'($urandom()));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule